// File: doc/BRIEF.md
# Frame-Synchronized Register List Loader

The block replays a list of register writes at every frame boundary of a continuously running display pipeline. Software stages a list by writing a base address and then a byte count together with an update flag. At the next frame-end pulse the block takes that address and count, clears the flag, and starts at once. It fetches each 8-byte entry from memory through a simple read port, one read in flight at a time, and issues each entry as a write on its register-write port. The settings therefore apply to the frame that follows.

While the update flag is set, the staged address and count belong to the hardware, and software writes to them are dropped. Once the flag reads back clear, the values have been copied into working registers, and software can stage the next list while the current one is still replaying. When a list has been fully replayed, a one-cycle completion pulse tells software that the list buffer may be reused. A frame end that arrives during a replay sets a sticky overrun flag and is otherwise ignored.

Top module: `dll_loader`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, rd_upd, mem_req, wr_en, display_start and overrun are 0.
- R2: While rd_upd is 1, writes to the address and size registers are ignored, and rd_addr and rd_size keep their values. While rd_upd is 0, writes take effect on the next clock edge.
- R3: The size write word carries the byte count in bits [SZW-1:0] and the update flag in bit SZW. The entry count is the byte count divided by 8, and the low three bits are ignored.
- R4: A frame-end pulse with rd_upd at 1 and no replay in progress accepts the list, and rd_upd reads 0 in the next cycle.
- R5: Entry i is read from mem_addr = base + 8*i, where the low three bits of the base are taken as zero. Entries are read in ascending order, and each mem_req is a single-cycle pulse with at most one read outstanding. Memory word bits [RAW+31:32] give wr_addr and bits [31:0] give wr_data, and each entry produces exactly one wr_en pulse in list order.
- R6: display_start is a single-cycle pulse per accepted list. For a non-empty list it comes in the same cycle as the last wr_en.
- R7: A frame end with rd_upd at 0 starts nothing. A flag that is set after a frame end waits for the following frame end.
- R8: A frame end during a replay sets overrun, which stays at 1 until reset. That frame end accepts no list, and the replay in progress completes unchanged.
- R9: A list with an entry count of 0 is accepted. display_start pulses in the cycle after the frame end, with no mem_req and no wr_en.
- R10: Register writes made after acceptance, while a replay is in progress, change only the readback and do not alter the list being replayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_addr_we | input | 1 | Write strobe for the list base address |
| sw_addr_wdata | input | AW | Base address write data |
| sw_size_we | input | 1 | Write strobe for the size/update register |
| sw_size_wdata | input | SZW+1 | Bit SZW is the update flag, bits [SZW-1:0] are the byte count |
| frame_end | input | 1 | Single-cycle frame-end pulse |
| rd_addr | output | AW | Readback of the staged base address |
| rd_size | output | SZW | Readback of the staged byte count |
| rd_upd | output | 1 | Readback of the update flag |
| mem_req | output | 1 | Memory read request, one cycle |
| mem_addr | output | AW | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 2*DW | Memory read data: register address in the upper half, data in the lower half |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | RAW | Register write address |
| wr_data | output | DW | Register write data |
| display_start | output | 1 | List-complete pulse |
| overrun | output | 1 | Sticky flag: a frame end arrived during a replay |

## Verification
A wrong remaining-entry count or a wrong address step shows up at the next completion as a missing or extra wr_en, or as a write whose address or data does not match the entry expected at that position. A lost busy state shows up on the first frame end that overlaps a replay, through overrun or an early acceptance. A wrongly held update flag shows up one cycle after the accepting frame end in rd_upd. The bench sweeps list lengths, bases and memory latencies and computes every expected entry arithmetically from its index.

// File: rtl/dll_pkg.sv
package dll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } dll_state_e;
endpackage

// File: rtl/dll_sw_regs.sv
module dll_sw_regs #(
    parameter int AW  = 16,
    parameter int SZW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           addr_we,
    input  logic [AW-1:0]  addr_wdata,
    input  logic           size_we,
    input  logic [SZW:0]   size_wdata,
    input  logic           accept,
    output logic [AW-1:0]  addr_q,
    output logic [SZW-1:0] size_q,
    output logic           upd_q
);
    typedef struct packed {
        logic [AW-1:0]  addr;
        logic [SZW-1:0] size;
        logic           upd;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.upd = 1'b0;
        end else if (!r_q.upd) begin
            if (addr_we) r_d.addr = addr_wdata;
            if (size_we) begin
                r_d.size = size_wdata[SZW-1:0];
                r_d.upd  = size_wdata[SZW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr_q = r_q.addr;
    assign size_q = r_q.size;
    assign upd_q  = r_q.upd;
endmodule

// File: rtl/dll_replay.sv
module dll_replay
    import dll_pkg::*;
#(
    parameter int AW  = 16,
    parameter int SZW = 12,
    parameter int RAW = 16,
    parameter int DW  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_end,
    input  logic            upd_in,
    input  logic [AW-1:0]   addr_in,
    input  logic [SZW-1:0]  size_in,
    output logic            accept,
    output logic            busy,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_rvalid,
    input  logic [2*DW-1:0] mem_rdata,
    output logic            wr_en,
    output logic [RAW-1:0]  wr_addr,
    output logic [DW-1:0]   wr_data,
    output logic            done,
    output logic            ovr
);
    localparam int CNTW = SZW - 3;

    typedef struct packed {
        dll_state_e      state;
        logic [AW-1:0]   cur_addr;
        logic [CNTW-1:0] left;
        logic            wr_en;
        logic [RAW-1:0]  wr_addr;
        logic [DW-1:0]   wr_data;
        logic            done;
        logic            ovr;
    } fsm_t;

    fsm_t s_q, s_d;

    always_comb begin
        s_d       = s_q;
        s_d.wr_en = 1'b0;
        s_d.done  = 1'b0;
        accept    = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (frame_end && upd_in) begin
                    accept       = 1'b1;
                    s_d.cur_addr = {addr_in[AW-1:3], 3'b000};
                    s_d.left     = size_in[SZW-1:3];
                    if (size_in[SZW-1:3] == '0) s_d.done  = 1'b1;
                    else                        s_d.state = ST_REQ;
                end
            end
            ST_REQ: s_d.state = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid) begin
                    s_d.wr_en   = 1'b1;
                    s_d.wr_addr = mem_rdata[DW+RAW-1:DW];
                    s_d.wr_data = mem_rdata[DW-1:0];
                    if (s_q.left == CNTW'(1)) begin
                        s_d.done  = 1'b1;
                        s_d.state = ST_IDLE;
                    end else begin
                        s_d.left     = s_q.left - CNTW'(1);
                        s_d.cur_addr = s_q.cur_addr + AW'(8);
                        s_d.state    = ST_REQ;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
        if (frame_end && s_q.state != ST_IDLE) s_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = (s_q.state != ST_IDLE);
    assign mem_req  = (s_q.state == ST_REQ);
    assign mem_addr = s_q.cur_addr;
    assign wr_en    = s_q.wr_en;
    assign wr_addr  = s_q.wr_addr;
    assign wr_data  = s_q.wr_data;
    assign done     = s_q.done;
    assign ovr      = s_q.ovr;
endmodule

// File: rtl/dll_loader.sv
module dll_loader #(
    parameter int AW  = 16,
    parameter int SZW = 12,
    parameter int RAW = 16,
    parameter int DW  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_addr_we,
    input  logic [AW-1:0]   sw_addr_wdata,
    input  logic            sw_size_we,
    input  logic [SZW:0]    sw_size_wdata,
    input  logic            frame_end,
    output logic [AW-1:0]   rd_addr,
    output logic [SZW-1:0]  rd_size,
    output logic            rd_upd,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_rvalid,
    input  logic [2*DW-1:0] mem_rdata,
    output logic            wr_en,
    output logic [RAW-1:0]  wr_addr,
    output logic [DW-1:0]   wr_data,
    output logic            display_start,
    output logic            overrun
);
    logic accept;
    logic busy;

    dll_sw_regs #(.AW(AW), .SZW(SZW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_we    (sw_addr_we),
        .addr_wdata (sw_addr_wdata),
        .size_we    (sw_size_we),
        .size_wdata (sw_size_wdata),
        .accept     (accept),
        .addr_q     (rd_addr),
        .size_q     (rd_size),
        .upd_q      (rd_upd)
    );

    dll_replay #(.AW(AW), .SZW(SZW), .RAW(RAW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .upd_in     (rd_upd),
        .addr_in    (rd_addr),
        .size_in    (rd_size),
        .accept     (accept),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .done       (display_start),
        .ovr        (overrun)
    );
endmodule

// File: rtl/dll_loader_chk.sv
module dll_loader_chk #(
    parameter int AW  = 16,
    parameter int SZW = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           frame_end,
    input logic           rd_upd,
    input logic [AW-1:0]  rd_addr,
    input logic [SZW-1:0] rd_size,
    input logic           busy,
    input logic           mem_req,
    input logic           wr_en,
    input logic           display_start,
    input logic           overrun
);
    assert_owned_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_upd |=> ($stable(rd_addr) && $stable(rd_size)));

    assert_accept_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && rd_upd && !busy) |=> !rd_upd);

    assert_single_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(frame_end && rd_upd)) |=> (!mem_req && !wr_en));

    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && busy) |=> overrun);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_empty_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && rd_upd && !busy && rd_size[SZW-1:3] == '0) |=> (display_start && !busy));
endmodule

bind dll_loader dll_loader_chk #(.AW(AW), .SZW(SZW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_end     (frame_end),
    .rd_upd        (rd_upd),
    .rd_addr       (rd_addr),
    .rd_size       (rd_size),
    .busy          (busy),
    .mem_req       (mem_req),
    .wr_en         (wr_en),
    .display_start (display_start),
    .overrun       (overrun)
);

// File: tb/sim_dll_loader.sv
`timescale 1ns/1ps
module sim_dll_loader;
    localparam int AW = 16, SZW = 12, RAW = 16, DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sw_addr_we = 1'b0;
    logic [AW-1:0]   sw_addr_wdata = '0;
    logic            sw_size_we = 1'b0;
    logic [SZW:0]    sw_size_wdata = '0;
    logic            frame_end = 1'b0;
    logic [AW-1:0]   rd_addr;
    logic [SZW-1:0]  rd_size;
    logic            rd_upd;
    logic            mem_req;
    logic [AW-1:0]   mem_addr;
    logic            mem_rvalid = 1'b0;
    logic [2*DW-1:0] mem_rdata = '0;
    logic            wr_en;
    logic [RAW-1:0]  wr_addr;
    logic [DW-1:0]   wr_data;
    logic            display_start;
    logic            overrun;

    int n_checks = 0;
    int n_fail   = 0;
    int lat      = 1;
    int exp_word = 0;
    int exp_n    = 0;
    int wr_seen  = 0;
    int ds_cnt   = 0;
    int req_cnt  = 0;
    int cnt      = 0;
    logic [AW-1:0] pend_addr = '0;

    always #2.5 clk = ~clk;

    dll_loader #(.AW(AW), .SZW(SZW), .RAW(RAW), .DW(DW)) u0 (.*);

    function automatic logic [63:0] ent(input int w);
        logic [63:0] r;
        r[63:48] = 16'h0;
        r[47:32] = 16'(w * 37 + 5);
        r[31:0]  = (32'(w) * 32'h0001_0003) ^ 32'h5A5A_0000;
        return r;
    endfunction

    // memory model, latency lat cycles
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            pend_addr <= mem_addr;
            cnt       <= lat;
        end else if (cnt > 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= ent(int'(pend_addr[AW-1:3]));
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard (R5, R6)
    always @(negedge clk) begin
        if (rst_n && mem_req) req_cnt++;
        if (rst_n && wr_en) begin
            logic [63:0] e;
            e = ent((exp_word + wr_seen) % 8192);
            check(wr_seen < exp_n, "R5 write count", wr_seen + 1, exp_n);
            check(wr_addr == e[47:32], "R5 wr_addr", wr_addr, e[47:32]);
            check(wr_data == e[31:0], "R5 wr_data", wr_data, e[31:0]);
            wr_seen++;
        end
        if (rst_n && display_start) begin
            ds_cnt++;
            check(wr_en == (exp_n != 0), "R6 done with last write", wr_en, exp_n != 0);
        end
    end

    task automatic sw_addr(input logic [AW-1:0] a);
        @(negedge clk); sw_addr_we = 1'b1; sw_addr_wdata = a;
        @(negedge clk); sw_addr_we = 1'b0;
    endtask

    task automatic sw_size(input int bytes, input logic upd);
        @(negedge clk); sw_size_we = 1'b1; sw_size_wdata = {upd, SZW'(bytes)};
        @(negedge clk); sw_size_we = 1'b0;
    endtask

    task automatic pulse_fe();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    task automatic arm(input int base, input int bytes);
        exp_word = (base / 8) % 8192;
        exp_n    = (bytes % 4096) / 8;
        wr_seen  = 0;
        ds_cnt   = 0;
        req_cnt  = 0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (ds_cnt == 0 && t < 500) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        check(ds_cnt == 1, req, ds_cnt, 1);
        check(wr_seen == exp_n, "R5 entries replayed", wr_seen, exp_n);
        check(req_cnt == exp_n, "R5 reads issued", req_cnt, exp_n);
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(!rd_upd && !mem_req && !wr_en && !display_start && !overrun, "R1 in reset", 1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_upd && !mem_req && !wr_en && !display_start && !overrun, "R1 after reset", 1, 0);

        // sweep over lengths, bases (unaligned low bits) and latencies: R3, R4, R5, R6
        for (int l = 1; l <= 3; l += 2) begin
            lat = l;
            for (int b = 0; b < 3; b++) begin
                for (int n = 0; n < 6; n++) begin
                    int base;
                    int bytes;
                    base  = (b * 16'h0528 + 16'hFFB0 * (b == 2)) % 65536 + (n % 8);
                    bytes = n * 8 + ((n * 3) % 8);
                    arm(base, bytes);
                    sw_addr(AW'(base));
                    sw_size(bytes, 1'b1);
                    check(rd_upd == 1'b1, "R3 update flag set", rd_upd, 1);
                    check(rd_size == SZW'(bytes), "R3 size readback", rd_size, bytes);
                    pulse_fe();
                    check(rd_upd == 1'b0, "R4 flag cleared after accept", rd_upd, 0);
                    if (n == 0) check(display_start == 1'b1, "R9 empty list done next cycle", display_start, 1);
                    wait_done("R6 one done pulse");
                end
            end
        end

        // R2: writes ignored while flag set
        lat = 2;
        arm(16'h0200, 24);
        sw_addr(16'h0200);
        sw_size(24, 1'b1);
        sw_addr(16'h3000);
        sw_size(40, 1'b0);
        check(rd_addr == 16'h0200, "R2 address kept", rd_addr, 16'h0200);
        check(rd_size == SZW'(24) && rd_upd, "R2 size and flag kept", rd_size, 24);
        pulse_fe();
        wait_done("R2 original list replayed");

        // R7: frame end without flag does nothing, later flag waits for next frame end
        arm(16'h0400, 16);
        pulse_fe();
        repeat (8) @(negedge clk);
        check(req_cnt == 0 && ds_cnt == 0, "R7 no activity without flag", req_cnt + ds_cnt, 0);
        sw_addr(16'h0400);
        sw_size(16, 1'b1);
        repeat (8) @(negedge clk);
        check(rd_upd == 1'b1 && req_cnt == 0, "R7 flag waits for frame end", rd_upd, 1);
        pulse_fe();
        wait_done("R7 list taken at next frame end");

        // R8, R10: overrun and staging during replay
        lat = 4;
        arm(16'h0800, 40);
        sw_addr(16'h0800);
        sw_size(40, 1'b1);
        pulse_fe();
        sw_addr(16'h0A00);
        sw_size(16, 1'b1);
        check(rd_addr == 16'h0A00 && rd_upd, "R10 staging accepted during replay", rd_addr, 16'h0A00);
        pulse_fe();
        check(overrun == 1'b1, "R8 overrun set", overrun, 1);
        check(rd_upd == 1'b1, "R8 update not taken during replay", rd_upd, 1);
        wait_done("R10 running list unaltered");
        arm(16'h0A00, 16);
        pulse_fe();
        check(rd_upd == 1'b0, "R8 deferred list accepted", rd_upd, 0);
        wait_done("R8 deferred list replayed");
        check(overrun == 1'b1, "R8 overrun sticky", overrun, 1);

        finish_run();
    end
endmodule